// File: doc/BRIEF.md
# Protected Boot-Window Word Memory with Indirect Address Walker

This block is the main word store of a small 16-bit minicomputer. It keeps a fixed window of 32 words at octal 040–077 that holds a boot image. When write protection is on, stores into that window are refused. A read request can be marked indirect. The block then follows a chain of pointer words until it finds one whose top bit is clear. When a pointer is read from one of eight auto-increment cells, that cell is bumped and written back before its value is used.

A processor presents one request at a time: address, indirect flag, read or write, and write data. It waits for the `done` pulse, which carries the read word, the effective address and a protection-violation flag. Two boot images can be copied into the window at run time, and loading either one turns protection on. A clear command wipes the store. Protection can also be set or removed directly.

Top module: `protected_core_mem`

## Requirements
- R1: After reset `busy`, `done` and `wr_violation` are low, protection is on whenever the `BOOT_ROM` parameter is 1 or 2, the window holds that boot image, and every other word reads zero.
- R2: A direct read accepted at a clock edge raises `done` for one cycle right after that edge, with `rd_data` equal to the stored word and `eff_addr` equal to `req_addr`.
- R3: A direct write stores the 16-bit `req_wdata` at `req_addr` and raises `done` right after the accepting edge, with `eff_addr` equal to the target.
- R4: While protection is on, a write whose target lies in octal 040–077 leaves memory unchanged and raises `wr_violation` together with `done`. With protection off the same write takes effect and `wr_violation` stays low.
- R5: An indirect read follows pointer words for as long as bit 15 of the fetched word is set, with no limit on chain length. After n pointer reads, `done` comes n+1 cycles later than for a direct read. `rd_data` is the word at the final address, and `busy` is high throughout. A chain that never ends keeps `busy` high with no `done`.
- R6: When an indirect step reads a pointer from octal 010–017, that cell is incremented modulo 2^16 and written back. The incremented value is then used as the pointer.
- R7: An indirect write resolves exactly one level. The target is the low address bits of the word at `req_addr`, whatever its bit 15. No auto-increment takes place, and the protection check applies to the resolved target.
- R8: `clear` zeroes every word in the cycle it is sampled, except the window while protection is on. A clear wins over a write in the same cycle.
- R9: `rom_load` with `rom_sel` 1 writes word i of the window as 0xB000 + 0x0101·i. With `rom_sel` 2 it writes 0xC000 + 0x0203·i. Either load turns protection on. With `rom_sel` 0 or 3 nothing is copied and protection stays as it was.
- R10: `prot_we` sets protection to `prot_val`. An image load in the same cycle takes precedence.
- R11: Pointer words and indirect-write targets are reduced to their low `ADDR_W` bits. Bits between `ADDR_W` and 14 have no effect on the resolved address.
- R12: A request is ignored while `busy` is high, and also in any cycle where `clear` or `rom_load` is asserted. Such a request produces no `done` and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_indirect | input | 1 | Resolve the address through pointer words |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 16 | Store data |
| busy | output | 1 | Indirect chain in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word read by the last completed load |
| eff_addr | output | ADDR_W | Resolved address of the last completed request |
| wr_violation | output | 1 | Store refused by protection, valid with `done` |
| rom_sel | input | 2 | Image to load: 0 none, 1 tape, 2 teletype, 3 none |
| rom_load | input | 1 | Copy the selected image into the window |
| prot_we | input | 1 | Update protection from `prot_val` |
| prot_val | input | 1 | New protection state |
| clear | input | 1 | Zero the store, sparing the window if protected |

## Verification
The bench drives a pointer chain that passes through an auto-increment cell. It checks both the latency and the written-back cell value. A walker that used the cell before bumping it, or bumped it after use, would end at the wrong address or leave a stale count behind. It also wraps an auto-increment cell from 0xFFFF to zero. A walker that kept a carry into bit 15 would run on instead of stopping. Pointers carrying junk in bits 10–14 catch missing masking. An indirect store through a pointer with bit 15 set and through an auto-increment cell catches a store path that chains or increments. Protected, unprotected and simultaneous load-plus-protect cases catch a reversed priority or a "none" selection that clears protection. A request slipped in during a walk or alongside a load must vanish without trace. A self-referencing chain must keep the block busy indefinitely.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   localparam int unsigned WORD_W     = 16;
   localparam int unsigned WIN_BASE   = 'o40;
   localparam int unsigned WIN_WORDS  = 'o40;
   localparam int unsigned WIN_IW     = $clog2(WIN_WORDS);
   localparam int unsigned AUTO_BASE  = 'o10;
   localparam int unsigned AUTO_WORDS = 8;

   typedef enum logic [1:0] {
      IMG_NONE = 2'd0,
      IMG_TAPE = 2'd1,
      IMG_TTY  = 2'd2
   } img_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WALK  = 2'd1,
      ST_FETCH = 2'd2
   } walk_st_e;

   typedef logic [WIN_WORDS-1:0][WORD_W-1:0] win_img_t;

   // boot image contents, computed per word
   function automatic logic [WORD_W-1:0] img_word(img_sel_e sel, int unsigned idx);
      logic [WORD_W-1:0] k;
      k = WORD_W'(idx);
      case (sel)
         IMG_TAPE: return 16'hB000 + k * 16'h0101;
         IMG_TTY:  return 16'hC000 + k * 16'h0203;
         default:  return '0;
      endcase
   endfunction

endpackage

// File: rtl/pcm_range_hit.sv
module pcm_range_hit #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LO     = 0,
   parameter int unsigned COUNT  = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam logic [ADDR_W:0] LO_X = (ADDR_W+1)'(LO);
   localparam logic [ADDR_W:0] HI_X = (ADDR_W+1)'(LO + COUNT);

   if (COUNT == 0 || LO + COUNT > (1 << ADDR_W)) begin : g_bad_range
      $error("pcm_range_hit: range does not fit the address space");
   end

   assign hit_o = ({1'b0, addr_i} >= LO_X) && ({1'b0, addr_i} < HI_X);

endmodule

// File: rtl/pcm_rom_image.sv
module pcm_rom_image
   import pcm_pkg::*;
(
   input  img_sel_e sel_i,
   output win_img_t img_o
);
   for (genvar i = 0; i < WIN_WORDS; i++) begin : g_word
      assign img_o[i] = img_word(sel_i, i);
   end
endmodule

// File: rtl/pcm_word_store.sv
module pcm_word_store
   import pcm_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              keep_win_i,
   input  logic              load_i,
   input  win_img_t          load_img_i,
   input  win_img_t          boot_img_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [WORD_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem_q [DEPTH];

   function automatic bit in_win(int unsigned a);
      return (a >= WIN_BASE) && (a < WIN_BASE + WIN_WORDS);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned i = 0; i < DEPTH; i++) begin
            mem_q[ADDR_W'(i)] <= '0;
         end
         for (int unsigned j = 0; j < WIN_WORDS; j++) begin
            mem_q[ADDR_W'(WIN_BASE + j)] <= boot_img_i[WIN_IW'(j)];
         end
      end else begin
         if (clear_i) begin
            for (int unsigned i = 0; i < DEPTH; i++) begin
               if (!(keep_win_i && in_win(i))) begin
                  mem_q[ADDR_W'(i)] <= '0;
               end
            end
         end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
         end
         if (load_i) begin
            for (int unsigned j = 0; j < WIN_WORDS; j++) begin
               mem_q[ADDR_W'(WIN_BASE + j)] <= load_img_i[WIN_IW'(j)];
            end
         end
      end
   end

   assign rdata_o = mem_q[raddr_i];

   AST_NO_WIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && keep_win_i) |-> !in_win(int'(waddr_i)))
      else $error("protected window written"); // R4

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (mem_q[DEPTH-1] == '0))
      else $error("clear left a word set"); // R8

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (mem_q[WIN_BASE] == $past(load_img_i[0])))
      else $error("image load missed window"); // R9

endmodule

// File: rtl/protected_core_mem.sv
module protected_core_mem
   import pcm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned BOOT_ROM = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_indirect,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   output logic              busy,
   output logic              done,
   output logic [15:0]       rd_data,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              wr_violation,
   input  logic [1:0]        rom_sel,
   input  logic              rom_load,
   input  logic              prot_we,
   input  logic              prot_val,
   input  logic              clear
);
   localparam int unsigned PTR_FLAG = WORD_W - 1;

   if (ADDR_W < 7 || ADDR_W > PTR_FLAG) begin : g_bad_aw
      $error("protected_core_mem: ADDR_W must lie between 7 and 15");
   end
   if (BOOT_ROM > 2) begin : g_bad_boot
      $error("protected_core_mem: BOOT_ROM must be 0, 1 or 2");
   end

   walk_st_e          st_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] eff_q;
   logic [WORD_W-1:0] rd_q;
   logic              done_q;
   logic              viol_q;
   logic              prot_q;

   img_sel_e sel_e;
   logic     img_ok;
   assign sel_e  = img_sel_e'(rom_sel);
   assign img_ok = (sel_e == IMG_TAPE) || (sel_e == IMG_TTY);

   logic accept;
   assign accept = req_valid && (st_q == ST_IDLE) && !clear && !rom_load;

   // single read port: request address when idle, walk cursor otherwise
   logic [ADDR_W-1:0] raddr;
   logic [WORD_W-1:0] rword;
   assign raddr = (st_q == ST_IDLE) ? req_addr : cur_q;

   logic [ADDR_W-1:0] wr_tgt;
   logic              tgt_win;
   assign wr_tgt = req_indirect ? rword[ADDR_W-1:0] : req_addr;

   pcm_range_hit #(.ADDR_W(ADDR_W), .LO(WIN_BASE), .COUNT(WIN_WORDS)) u_win_hit (
      .addr_i (wr_tgt),
      .hit_o  (tgt_win)
   );

   logic cur_auto;
   pcm_range_hit #(.ADDR_W(ADDR_W), .LO(AUTO_BASE), .COUNT(AUTO_WORDS)) u_auto_hit (
      .addr_i (cur_q),
      .hit_o  (cur_auto)
   );

   logic [WORD_W-1:0] ptr_next;
   assign ptr_next = cur_auto ? (rword + 16'd1) : rword;

   logic              st_we;
   logic [ADDR_W-1:0] st_waddr;
   logic [WORD_W-1:0] st_wdata;

   always_comb begin
      st_we    = 1'b0;
      st_waddr = wr_tgt;
      st_wdata = req_wdata;
      if (st_q == ST_WALK) begin
         st_we    = cur_auto;
         st_waddr = cur_q;
         st_wdata = ptr_next;
      end else if (accept && req_write) begin
         st_we    = !(prot_q && tgt_win);
      end
   end

   win_img_t boot_img;
   win_img_t load_img;

   if (BOOT_ROM == 0) begin : g_no_boot
      assign boot_img = '0;
   end else begin : g_boot
      pcm_rom_image u_boot_img (
         .sel_i (img_sel_e'(2'(BOOT_ROM))),
         .img_o (boot_img)
      );
   end

   pcm_rom_image u_load_img (
      .sel_i (sel_e),
      .img_o (load_img)
   );

   pcm_word_store #(.ADDR_W(ADDR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear),
      .keep_win_i (prot_q),
      .load_i     (rom_load && img_ok),
      .load_img_i (load_img),
      .boot_img_i (boot_img),
      .we_i       (st_we),
      .waddr_i    (st_waddr),
      .wdata_i    (st_wdata),
      .raddr_i    (raddr),
      .rdata_o    (rword)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= (BOOT_ROM != 0);
      end else if (rom_load && img_ok) begin
         prot_q <= 1'b1;
      end else if (prot_we) begin
         prot_q <= prot_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cur_q  <= '0;
         eff_q  <= '0;
         rd_q   <= '0;
         done_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         viol_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  if (req_write) begin
                     done_q <= 1'b1;
                     viol_q <= prot_q && tgt_win;
                     eff_q  <= wr_tgt;
                  end else if (req_indirect) begin
                     cur_q <= req_addr;
                     st_q  <= ST_WALK;
                  end else begin
                     done_q <= 1'b1;
                     rd_q   <= rword;
                     eff_q  <= req_addr;
                  end
               end
            end
            ST_WALK: begin
               cur_q <= ptr_next[ADDR_W-1:0];
               if (!ptr_next[PTR_FLAG]) begin
                  st_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               rd_q   <= rword;
               eff_q  <= cur_q;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (st_q != ST_IDLE);
   assign done         = done_q;
   assign rd_data      = rd_q;
   assign eff_addr     = eff_q;
   assign wr_violation = viol_q;

   AST_VIOL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_violation |-> done)
      else $error("violation without completion"); // R4

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("completion while walking"); // R12

   AST_WALK_HOLDS_EFF: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WALK) |=> $stable(eff_addr))
      else $error("result moved mid-walk"); // R5

   AST_IMG_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_load && img_ok) |=> prot_q)
      else $error("image load left window open"); // R9

   AST_NONE_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_load && !img_ok && !prot_we) |=> $stable(prot_q))
      else $error("empty selection changed protection"); // R9

endmodule

// File: tb/protected_core_mem_bench.sv
module protected_core_mem_bench;
   localparam int unsigned AW    = 10;
   localparam int unsigned DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_write, req_indirect;
   logic [AW-1:0] req_addr;
   logic [15:0]   req_wdata;
   logic          busy, done, wr_violation;
   logic [15:0]   rd_data;
   logic [AW-1:0] eff_addr;
   logic [1:0]    rom_sel;
   logic          rom_load, prot_we, prot_val, clear;

   always #4 clk = ~clk;

   protected_core_mem #(.ADDR_W(AW), .BOOT_ROM(1)) u_protected_core_mem (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_indirect(req_indirect), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .eff_addr(eff_addr),
      .wr_violation(wr_violation), .rom_sel(rom_sel), .rom_load(rom_load),
      .prot_we(prot_we), .prot_val(prot_val), .clear(clear)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] m [DEPTH];
   bit pm;

   function automatic logic [15:0] img(int s, int i);
      if (s == 1) return 16'hB000 + 16'(i) * 16'h0101;
      if (s == 2) return 16'hC000 + 16'(i) * 16'h0203;
      return 16'h0000;
   endfunction

   function automatic bit in_win(int a);
      return (a >= 'o40) && (a <= 'o77);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) m[i] = '0;
      for (int j = 0; j < 32; j++) m['o40 + j] = img(1, j);
      pm = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 0; req_write = 0; req_indirect = 0; req_addr = '0; req_wdata = '0;
      rom_sel = '0; rom_load = 0; prot_we = 0; prot_val = 0; clear = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "done after reset", done, 0);
      chk("R1", "violation after reset", wr_violation, 0);
   endtask

   task automatic wait_done(output int lat);
      lat = 1;
      while (!done && lat < 3000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic do_op(input string tag, input bit wr, input bit ind, input int a, input logic [15:0] d);
      int cur, n, lat, exp_eff, exp_lat;
      logic [15:0] p, exp_rd;
      bit exp_v;
      exp_v = 0; exp_rd = '0;
      if (wr) begin
         cur = ind ? int'(m[a][AW-1:0]) : a;
         exp_v = pm && in_win(cur);
         if (!exp_v) m[cur] = d;
         exp_eff = cur; exp_lat = 1;
      end else if (!ind) begin
         exp_rd = m[a]; exp_eff = a; exp_lat = 1;
      end else begin
         cur = a; n = 0;
         do begin
            p = m[cur];
            if (cur >= 'o10 && cur <= 'o17) begin
               p = p + 16'd1;
               m[cur] = p;
            end
            n++;
            cur = int'(p[AW-1:0]);
         end while (p[15] && n < 1000);
         exp_rd = m[cur]; exp_eff = cur; exp_lat = n + 2;
      end
      @(negedge clk);
      req_valid = 1; req_write = wr; req_indirect = ind; req_addr = AW'(a); req_wdata = d;
      @(negedge clk);
      req_valid = 0;
      wait_done(lat);
      chk(tag, "latency", lat, exp_lat);
      chk(tag, "eff_addr", eff_addr, exp_eff);
      chk(tag, "wr_violation", wr_violation, exp_v);
      if (!wr) chk(tag, "rd_data", rd_data, exp_rd);
   endtask

   task automatic ctl(input bit ld, input int sel, input bit pwe, input bit pv, input bit clr);
      @(negedge clk);
      rom_load = ld; rom_sel = 2'(sel); prot_we = pwe; prot_val = pv; clear = clr;
      @(negedge clk);
      rom_load = 0; prot_we = 0; clear = 0;
      if (clr) begin
         for (int i = 0; i < DEPTH; i++) if (!(pm && in_win(i))) m[i] = '0;
      end
      if (ld && (sel == 1 || sel == 2)) begin
         for (int j = 0; j < 32; j++) m['o40 + j] = img(sel, j);
         pm = 1'b1;
      end else if (pwe) begin
         pm = pv;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int lat;
      do_reset();
      // R1: boot image and zeroed remainder
      do_op("R1", 0, 0, 'o40, 0);
      do_op("R1", 0, 0, 'o77, 0);
      do_op("R1", 0, 0, 'o100, 0);
      // R2 R3: direct store and load
      do_op("R3", 1, 0, 'h100, 16'hA5A5);
      do_op("R2", 0, 0, 'h100, 0);
      do_op("R3", 1, 0, 'h3FF, 16'hFFFF);
      do_op("R2", 0, 0, 'h3FF, 0);
      // R4: protected window refuses stores
      do_op("R4", 1, 0, 'o45, 16'h1234);
      do_op("R4", 0, 0, 'o45, 0);
      do_op("R4", 1, 0, 'o37, 16'h0ACE);
      do_op("R4", 1, 0, 'o100, 16'h0BEE);
      // R10: protection off opens the window
      ctl(0, 0, 1, 0, 0);
      do_op("R10", 1, 0, 'o45, 16'h1234);
      do_op("R10", 0, 0, 'o45, 0);
      // R9: teletype image load protects
      ctl(1, 2, 0, 0, 0);
      do_op("R9", 0, 0, 'o40, 0);
      do_op("R9", 0, 0, 'o77, 0);
      do_op("R9", 1, 0, 'o50, 16'h7777);
      // R9: empty selection keeps state (both ways)
      ctl(1, 0, 0, 0, 0);
      do_op("R9", 1, 0, 'o51, 16'h7777);
      ctl(0, 0, 1, 0, 0);
      ctl(1, 3, 0, 0, 0);
      do_op("R9", 1, 0, 'o51, 16'h7777);
      do_op("R9", 0, 0, 'o51, 0);
      // R10: image load beats a simultaneous unprotect
      ctl(1, 1, 1, 0, 0);
      do_op("R10", 1, 0, 'o52, 16'h6666);
      do_op("R10", 0, 0, 'o52, 0);
      // R5 R6: chain through an auto-increment cell
      do_op("R5", 1, 0, 'h200, 16'h8210);
      do_op("R5", 1, 0, 'h210, 16'h800A);
      do_op("R6", 1, 0, 'o12, 16'h82FF);
      do_op("R5", 1, 0, 'h300, 16'h0345);
      do_op("R5", 1, 0, 'h301, 16'h0346);
      do_op("R5", 1, 0, 'h345, 16'h6789);
      do_op("R5", 1, 0, 'h346, 16'h4321);
      do_op("R5", 0, 1, 'h200, 0);
      do_op("R6", 0, 0, 'o12, 0);
      do_op("R6", 0, 1, 'h200, 0);
      do_op("R6", 0, 0, 'o12, 0);
      // R6: wrap of an auto-increment cell ends the chain
      do_op("R6", 1, 0, 'o17, 16'hFFFF);
      do_op("R6", 0, 1, 'o17, 0);
      do_op("R6", 0, 0, 'o17, 0);
      // R11: high pointer bits ignored
      do_op("R11", 1, 0, 'h220, 16'h7C55);
      do_op("R11", 1, 0, 'h055, 16'h2468);
      do_op("R11", 0, 1, 'h220, 0);
      do_op("R11", 1, 1, 'h220, 16'h1357);
      do_op("R11", 0, 0, 'h055, 0);
      // R7: single-level indirect stores
      do_op("R7", 1, 0, 'h230, 16'h8040);
      do_op("R7", 1, 1, 'h230, 16'h5A5A);
      do_op("R7", 0, 0, 'o40, 0);
      do_op("R7", 1, 0, 'h231, 16'h000B);
      do_op("R7", 1, 1, 'h231, 16'h0F0F);
      do_op("R7", 0, 0, 'o13, 0);
      do_op("R7", 0, 0, 'h231, 0);
      // R12: request during a walk is dropped
      do_op("R12", 1, 0, 'h280, 16'h8281);
      do_op("R12", 1, 0, 'h281, 16'h8282);
      do_op("R12", 1, 0, 'h282, 16'h0290);
      do_op("R12", 1, 0, 'h3F0, 16'h0101);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_indirect = 1; req_addr = AW'('h280);
      @(negedge clk);
      chk("R12", "busy during walk", busy, 1);
      req_write = 1; req_indirect = 0; req_addr = AW'('h3F0); req_wdata = 16'h5555;
      @(negedge clk);
      req_valid = 0;
      wait_done(lat);
      chk("R5", "chain eff_addr", eff_addr, 'h290);
      do_op("R12", 0, 0, 'h3F0, 0);
      // R12: request alongside an image load is dropped
      do_op("R12", 1, 0, 'h120, 16'h2222);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_indirect = 0; req_addr = AW'('h120); req_wdata = 16'h1111;
      rom_load = 1; rom_sel = 2'd0;
      @(negedge clk);
      req_valid = 0; rom_load = 0;
      chk("R12", "done with load", done, 0);
      do_op("R12", 0, 0, 'h120, 0);
      // R8: protected clear spares the window, unprotected clear does not
      ctl(0, 0, 0, 0, 1);
      do_op("R8", 0, 0, 'h100, 0);
      do_op("R8", 0, 0, 'o45, 0);
      do_op("R8", 0, 0, 'o12, 0);
      ctl(0, 0, 1, 0, 0);
      ctl(0, 0, 0, 0, 1);
      do_op("R8", 0, 0, 'o45, 0);
      do_op("R8", 0, 0, 'o77, 0);
      // random phase
      ctl(1, 1, 0, 0, 0);
      void'($urandom(32'd1234));
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[7:4] == 4'd0) begin
            ctl(0, 0, 1, r[8], 0);
         end else begin
            do_op(r[2] ? "R3" : (r[1] ? "R5" : "R2"), r[2], r[1],
                  int'($urandom_range(DEPTH - 1)), 16'($urandom) & 16'h7FFF);
         end
      end
      // R5: endless chain stays busy
      do_op("R5", 1, 0, 'h3A0, 16'h83A0);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_indirect = 1; req_addr = AW'('h3A0);
      @(negedge clk);
      req_valid = 0;
      repeat (60) @(negedge clk);
      chk("R5", "busy on endless chain", busy, 1);
      chk("R5", "done on endless chain", done, 0);
      do_reset();
      do_op("R1", 0, 0, 'o60, 0);
      do_op("R1", 0, 0, 'h3A0, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule